// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator with Coded Prescaler

This block generates one pulse-width modulated output from a system clock. Software programs it through two 32-bit registers on a simple synchronous bus: a control word that picks a clock divider from a fixed table of coded values, sets the active output level and turns the channel on, and a period word that holds the period length and the active time, both counted in prescaled ticks.

A period write does not take effect at once while the channel runs. The new value sits in the register until the current period ends, and a busy flag in the control word stays set until then. Software polls that flag before it writes the next setting. When the channel is stopped, a pending value loads on the next clock. A divider code outside the table stops the divider: the counters freeze and the output holds its level.

Top module: `pwm_unit`

## Requirements
- R1: After reset the output is 1, which is the inactive level for control value 0. A read of either register returns 0.
- R2: A read is issued with rd_en and its data appears on rdata on the next cycle. rdata is 0 in any cycle that does not follow a read. Offset 0x0 returns the last control word written, with bit 28 replaced by the live busy flag. Offset 0x4 returns the last period word written. Any other offset reads 0, and writes to it are ignored.
- R3: Control bits [3:0] select the clock divider: 0xF divides by 1, 0x0 by 120, 0x1 by 180, 0x2 by 240, 0x3 by 360, 0x4 by 480, 0x8 by 12000, 0x9 by 24000, 0xA by 36000, 0xB by 48000 and 0xC by 72000. One prescaled tick lasts that many clocks.
- R4: Period word bits [31:16] hold N and bits [15:0] hold M. Each period lasts N+1 ticks, and the output is active for the first M ticks of each period.
- R5: If M is at least N+1, the output stays active for the whole period. If M is 0, it stays inactive.
- R6: Control bit 5 sets the active level. With bit 5 at 1 the active level is high; with bit 5 at 0 the output is inverted.
- R7: The channel runs only when control bit 4 (enable) and bit 6 (clock on) are both 1. Otherwise the output drives the inverse of bit 5 on the next cycle, and the counters clear, so the channel restarts from the beginning of a period.
- R8: A write to offset 0x4 sets the busy flag (control bit 28). The new value becomes the working setting at the end of the current period, or on the next clock if the channel is stopped, and the flag then clears.
- R9: With the channel running and divider code 0x5, 0x6, 0x7, 0xD or 0xE, the counters freeze and the output holds its level, even if control bit 5 changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid on the cycle after rd_en |
| pwm_out | output | 1 | Modulated output |

## Verification
A wrong divider count or period counter first shows as an output edge in the wrong clock cycle. The per-cycle comparison against the reference catches it at the first misplaced edge, which is within one tick for the divider and within one period for the counter. A working setting that loads at the wrong time shows as a changed duty before the period boundary, or as a busy bit that is wrong on the next control read. A freeze or idle path that does not act leaves the output moving on the cycle after the control write, which is also where the output-level checks look.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int PSC_W    = 17;
    localparam int BIT_RUN  = 4;
    localparam int BIT_POL  = 5;
    localparam int BIT_CLK  = 6;
    localparam int BIT_BUSY = 28;

    typedef struct packed {
        logic             ok;
        logic [PSC_W-1:0] div;
    } psc_sel_t;

    function automatic psc_sel_t psc_decode(input logic [3:0] code);
        psc_sel_t r;
        r.ok = 1'b1;
        case (code)
            4'hF:    r.div = PSC_W'(1);
            4'h0:    r.div = PSC_W'(120);
            4'h1:    r.div = PSC_W'(180);
            4'h2:    r.div = PSC_W'(240);
            4'h3:    r.div = PSC_W'(360);
            4'h4:    r.div = PSC_W'(480);
            4'h8:    r.div = PSC_W'(12000);
            4'h9:    r.div = PSC_W'(24000);
            4'hA:    r.div = PSC_W'(36000);
            4'hB:    r.div = PSC_W'(48000);
            4'hC:    r.div = PSC_W'(72000);
            default: begin
                r.ok  = 1'b0;
                r.div = PSC_W'(1);
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
    parameter logic [ADDR_W-1:0] PER_OFS  = ADDR_W'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load_i,
    output logic [DATA_W-1:0] rdata,
    output logic [3:0]        code_o,
    output logic              run_o,
    output logic              pol_o,
    output logic [DATA_W-1:0] per_o,
    output logic              busy_o
);
    import pwm_pkg::*;

    localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << BIT_BUSY;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] per;
        logic              busy;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        st_d.rdata = '0;
        if (rd_en) begin
            if (addr == CTRL_OFS)
                st_d.rdata = (st_q.ctrl & ~BUSY_MASK) | (st_q.busy ? BUSY_MASK : '0);
            else if (addr == PER_OFS)
                st_d.rdata = st_q.per;
        end
        if (load_i)
            st_d.busy = 1'b0;
        if (wr_en) begin
            if (addr == CTRL_OFS)
                st_d.ctrl = wdata & ~BUSY_MASK;
            else if (addr == PER_OFS) begin
                st_d.per  = wdata;
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign code_o = st_q.ctrl[3:0];
    assign run_o  = st_q.ctrl[BIT_RUN] & st_q.ctrl[BIT_CLK];
    assign pol_o  = st_q.ctrl[BIT_POL];
    assign per_o  = st_q.per;
    assign busy_o = st_q.busy;
endmodule

// File: rtl/pwm_presc.sv
module pwm_presc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [3:0] code_i,
    output logic       tick_o,
    output logic       valid_o
);
    import pwm_pkg::*;

    typedef struct packed {
        logic [PSC_W-1:0] pc;
    } presc_t;

    presc_t   st_q, st_d;
    psc_sel_t sel;
    logic     hit;

    always_comb begin
        sel  = psc_decode(code_i);
        // a counter left above a smaller divider still wraps here
        hit  = st_q.pc >= (sel.div - PSC_W'(1));
        st_d = st_q;
        if (!run_i)
            st_d.pc = '0;
        else if (!sel.ok)
            st_d.pc = st_q.pc;
        else if (hit)
            st_d.pc = '0;
        else
            st_d.pc = st_q.pc + PSC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o  = run_i & sel.ok & hit;
    assign valid_o = sel.ok;
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               valid_i,
    input  logic               tick_i,
    input  logic               pol_i,
    input  logic               busy_i,
    input  logic [2*CNT_W-1:0] per_i,
    output logic               load_o,
    output logic [CNT_W-1:0]   duty_o,
    output logic               pwm_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] wper;
        logic [CNT_W-1:0] wduty;
        logic             out;
    } core_t;

    core_t st_q, st_d;
    logic  wrap, act;

    always_comb begin
        wrap   = tick_i & (st_q.cnt == st_q.wper);
        load_o = busy_i & (~run_i | wrap);
        act    = st_q.cnt < st_q.wduty;
        st_d   = st_q;
        if (!run_i)
            st_d.cnt = '0;
        else if (wrap)
            st_d.cnt = '0;
        else if (tick_i)
            st_d.cnt = st_q.cnt + CNT_W'(1);
        if (load_o) begin
            st_d.wper  = per_i[2*CNT_W-1:CNT_W];
            st_d.wduty = per_i[CNT_W-1:0];
        end
        if (!run_i)
            st_d.out = ~pol_i;
        else if (valid_i)
            st_d.out = pol_i ? act : ~act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.out <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_o = st_q.wduty;
    assign pwm_o  = st_q.out;
endmodule

// File: rtl/pwm_unit.sv
module pwm_unit #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              pwm_out
);
    localparam int DATA_W = 2 * CNT_W;

    logic [3:0]        code_w;
    logic              run_w, pol_w, busy_w, load_w, tick_w, valid_w;
    logic [DATA_W-1:0] per_w;
    logic [CNT_W-1:0]  duty_w;

    pwm_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CTRL_OFS(ADDR_W'(0)),
        .PER_OFS (ADDR_W'(4))
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .load_i(load_w), .rdata(rdata),
        .code_o(code_w), .run_o(run_w), .pol_o(pol_w),
        .per_o(per_w), .busy_o(busy_w)
    );

    pwm_presc u_presc (
        .clk(clk), .rst_n(rst_n), .run_i(run_w), .code_i(code_w),
        .tick_o(tick_w), .valid_o(valid_w)
    );

    pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run_i(run_w), .valid_i(valid_w),
        .tick_i(tick_w), .pol_i(pol_w), .busy_i(busy_w), .per_i(per_w),
        .load_o(load_w), .duty_o(duty_w), .pwm_o(pwm_out)
    );
endmodule

// File: rtl/pwm_unit_chk.sv
module pwm_unit_chk #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              pwm_out,
    input logic              run,
    input logic              pol,
    input logic              valid,
    input logic              busy,
    input logic [CNT_W-1:0]  duty
);
    // R8
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(4)) |=> busy);

    // R2
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == 32'h0));

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm_out == !$past(pol)));

    // R9
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !valid) |=> $stable(pwm_out));

    // R5
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && valid && duty == '0) |=> (pwm_out == !$past(pol)));
endmodule

bind pwm_unit pwm_unit_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .rdata(rdata), .pwm_out(pwm_out), .run(run_w), .pol(pol_w),
    .valid(valid_w), .busy(busy_w), .duty(duty_w)
);

// File: tb/sim_pwm_unit.sv
module sim_pwm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;

    int total = 0, bad = 0;

    pwm_unit u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

    always #4 clk = ~clk;

    // behavioural reference
    logic [31:0] m_ctrl, m_per, m_rd;
    logic        m_busy, m_out;
    int          m_wp, m_wd, m_cnt, m_pc;

    function automatic int ref_div(input logic [3:0] c);
        case (c)
            4'hF: return 1;      4'h0: return 120;   4'h1: return 180;
            4'h2: return 240;    4'h3: return 360;   4'h4: return 480;
            4'h8: return 12000;  4'h9: return 24000; 4'hA: return 36000;
            4'hB: return 48000;  4'hC: return 72000;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_per = 0; m_rd = 0; m_busy = 0; m_out = 1;
            m_wp = 0; m_wd = 0; m_cnt = 0; m_pc = 0;
        end else begin
            bit run, pol, tick, wrap, load, act;
            int d;
            run  = m_ctrl[4] && m_ctrl[6];
            pol  = m_ctrl[5];
            d    = ref_div(m_ctrl[3:0]);
            tick = run && d != 0 && m_pc >= d - 1;
            wrap = tick && m_cnt == m_wp;
            load = m_busy && (!run || wrap);
            act  = m_cnt < m_wd;
            m_rd = 0;
            if (rd_en && addr == 0) begin
                m_rd = m_ctrl;
                m_rd[28] = m_busy;
            end else if (rd_en && addr == 4) m_rd = m_per;
            if (!run) m_out = !pol;
            else if (d != 0) m_out = pol ? act : !act;
            if (!run) m_pc = 0;
            else if (d != 0) m_pc = tick ? 0 : m_pc + 1;
            if (!run || wrap) m_cnt = 0;
            else if (tick) m_cnt = m_cnt + 1;
            if (load) begin
                m_wp = int'(m_per[31:16]);
                m_wd = int'(m_per[15:0]);
                m_busy = 0;
            end
            if (wr_en && addr == 0) begin
                m_ctrl = wdata;
                m_ctrl[28] = 1'b0;
            end else if (wr_en && addr == 4) begin
                m_per = wdata;
                m_busy = 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference (R3, R4, R6, R7, R8, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            check("R4/R7 output vs reference", {31'b0, pwm_out}, {31'b0, m_out});
            check("R2 rdata vs reference", rdata, m_rd);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        rd_en = 1; addr = a;
        @(posedge clk); #1;
        rd_en = 0;
        check(tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    // set up while stopped, then start
    task automatic setup(input logic [31:0] ctrl, input logic [31:0] per);
        wr(0, ctrl & ~32'h50);
        wr(4, per);
        wr(0, ctrl);
        idle(4);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int h;
        logic held;
        idle(3);
        #1;
        check("R1 output after reset", {31'b0, pwm_out}, 32'h1);
        rst_n = 1;
        rd(0, 32'h0, "R1 control after reset");
        rd(4, 32'h0, "R1 period after reset");
        @(negedge clk);
        check("R2 rdata idle", rdata, 32'h0);

        // R2 readback and unmapped offset
        wr(4, 32'h0004_0002);
        rd(4, 32'h0004_0002, "R2 period readback");
        wr(8, 32'hFFFF_FFFF);
        rd(8, 32'h0, "R2 unmapped offset");
        rd(0, 32'h0, "R2 control unchanged, R8 busy cleared when stopped");

        // R4 N=4 M=2, divide by 1, active high
        setup(32'h7F, 32'h0004_0002);
        count_high(50, h);
        check("R4 duty 2 of 5", h, 20);
        rd(0, 32'h7F, "R2 control readback");

        // R6 inverted
        setup(32'h5F, 32'h0004_0002);
        count_high(50, h);
        check("R6 inverted duty", h, 30);

        // R5 full and zero
        setup(32'h7F, 32'h0004_0009);
        count_high(50, h);
        check("R5 duty above period", h, 50);
        setup(32'h7F, 32'h0004_0000);
        count_high(50, h);
        check("R5 zero duty", h, 0);

        // R7 partial enables
        wr(0, 32'h3F);
        idle(2);
        count_high(20, h);
        check("R7 clock off gives low", h, 0);
        wr(0, 32'h4F);
        idle(2);
        count_high(20, h);
        check("R7 enable off gives inverse level", h, 20);

        // R3 divide by 120, N=1 M=1: 240-clock period
        setup(32'h70, 32'h0001_0001);
        count_high(480, h);
        check("R3 divide by 120", h, 240);

        // R8 busy while running
        wr(4, 32'h0001_0002);
        rd(0, 32'h1000_0070, "R8 busy set after period write");
        rd(4, 32'h0001_0002, "R8 period holds new value");
        idle(600);
        rd(0, 32'h70, "R8 busy cleared at boundary");
        count_high(480, h);
        check("R8 new setting in force", h, 480);

        // R3 divide by 180, N=1 M=1
        setup(32'h71, 32'h0001_0001);
        count_high(720, h);
        check("R3 divide by 180", h, 360);

        // R3 divide by 12000, N=1 M=1
        setup(32'h78, 32'h0001_0001);
        count_high(48000, h);
        check("R3 divide by 12000", h, 24000);

        // R9 unlisted code freezes
        setup(32'h7F, 32'h0004_0002);
        idle(7);
        wr(0, 32'h75);
        @(negedge clk);
        held = pwm_out;
        count_high(30, h);
        check("R9 output frozen", h, held ? 30 : 0);
        wr(0, 32'h5D);
        idle(2);
        count_high(30, h);
        check("R9 frozen despite polarity change", h, held ? 30 : 0);
        wr(0, 32'h7F);
        count_high(50, h);
        check("R9 resumes after valid code", h, 20);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule